// File: doc/BRIEF.md
# Compartment Address Decoder

This block sits on the 32-bit register bus between a processor-side bus master and one interface block. The address space is cut into equal compartments whose size is a power of two. The block takes a window of the address that sits between a configurable number of ignored low bits and a configurable number of ignored high bits. It treats that window as a compartment number. The block answers only when that number lies inside its own inclusive start-to-end range.

Inside its range the block splits the address into 32-bit word slots, counted from the base of its start compartment. The first `NUM_REGS` slots are backed by registers. A write to a backed slot raises a one-hot write strobe in the same cycle, and the register takes the data at the next clock edge. A read returns the register contents combinationally. When the block is not addressed, its read data is zero, so the read buses of several decoders can be ORed together. A parameter set with an end below the start, or one that leaves no compartment bits, stops elaboration.

In the default configuration the compartment field is address bits 13:10 (1 KiB compartments), and the block owns compartments 1 and 2. That is byte offsets 0x400 to 0xBFF. Eight registers sit at 0x400 to 0x41C.

Top module: `comp_decoder`

## Requirements
- R1: After reset, every backed register reads back as zero.
- R2: `sel` is high exactly when the compartment field `addr[31-SHIFT_L:SHIFT_R]` lies between START_C and END_C inclusive. By default this is bits 13:10 in the range 1 to 2, so addresses 0x400 to 0xBFF are selected, and 0x3FC, 0xC00 and 0x1000 are not.
- R3: The top SHIFT_L address bits have no effect. For example, 0xFFFFC408 selects and reaches the same register as 0x408.
- R4: Within a selected compartment, the low SHIFT_R bits do not affect `sel`. Every address from 0x400 through 0xBFF asserts it.
- R5: The register index is `(addr[31-SHIFT_L:2] - START_C*2^(SHIFT_R-2))`, which is the word offset from the start compartment's base. Address bits 1:0 are ignored, so 0x40F reaches register 3.
- R6: When `wr` is high, the block is selected and the index is below NUM_REGS, `wstrb[index]` is the only strobe bit high in that same cycle. The register then holds `wdata` from the next clock edge.
- R7: A write while not selected raises no strobe and changes no register.
- R8: `rdata` is zero whenever `rd` is low or the block is not selected. Otherwise it is the indexed register.
- R9: An in-range index at or above NUM_REGS raises no strobe, reads zero, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 32 | Byte address |
| wdata | input | 32 | Write data |
| rd | input | 1 | Read request |
| wr | input | 1 | Write request |
| sel | output | 1 | Address falls in the owned compartment range |
| rdata | output | 32 | Read data, zero when not addressed |
| wstrb | output | NUM_REGS | One-hot write strobe per register |

## Verification
`sel`, `wstrb` and `rdata` are combinational from the bus inputs, so they are due in the same cycle as the stimulus. The bench drives inputs on the falling edge and samples these outputs one time step later, before the next rising edge. A register write only shows after the rising edge that follows the strobe. The bench therefore reads a written slot back in a later bus cycle, and it compares the result against a model array it updates from the requirements alone.

// File: rtl/comp_decoder.sv
module comp_decoder #(
  parameter int SHIFT_R  = 10,
  parameter int SHIFT_L  = 18,
  parameter int START_C  = 1,
  parameter int END_C    = 2,
  parameter int NUM_REGS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [31:0]         addr,
  input  logic [31:0]         wdata,
  input  logic                rd,
  input  logic                wr,
  output logic                sel,
  output logic [31:0]         rdata,
  output logic [NUM_REGS-1:0] wstrb
);
  localparam int DB   = 32 - SHIFT_L - SHIFT_R;
  localparam int TOP  = 31 - SHIFT_L;
  localparam int IW   = TOP - 1;
  localparam int RIW  = $clog2(NUM_REGS);
  localparam logic [IW-1:0] BASE_W = IW'(START_C * (2 ** (SHIFT_R - 2)));

  generate
    if (END_C < START_C || DB < 1 || SHIFT_R < 2 || NUM_REGS < 2) begin : g_bad_params
      $error("comp_decoder: illegal compartment parameters");
    end
  endgenerate

  logic [DB-1:0] comp;
  logic [IW-1:0] widx;
  logic          hit;
  logic [NUM_REGS-1:0][31:0] regs;
  logic unused_addr_bits;

  assign unused_addr_bits = ^{addr[31:TOP+1], addr[1:0]};
  assign comp = addr[TOP:SHIFT_R];
  assign sel  = (comp >= DB'(START_C)) && (comp <= DB'(END_C));
  assign widx = addr[TOP:2] - BASE_W;
  assign hit  = sel && (widx < IW'(NUM_REGS));

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    assign wstrb[k] = wr && hit && (widx == IW'(k));
    always_ff @(posedge clk) begin
      if (!rst_n)        regs[k] <= '0;
      else if (wstrb[k]) regs[k] <= wdata;
    end
  end

  assign rdata = (rd && hit) ? regs[widx[RIW-1:0]] : '0;

  // R6
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wstrb));

  // R7
  no_strobe_unsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> (wstrb == '0));

  // R8
  quiet_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel || !rd) |-> (rdata == '0));

  // R7
  regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wstrb == '0) |=> $stable(regs));

  // R6
  strobe_needs_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |-> (wstrb == '0));
endmodule

// File: tb/test_comp_decoder.sv
module test_comp_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 8;

  logic clk = 0, rst_n = 0, rd = 0, wr = 0;
  logic [31:0] addr = 0, wdata = 0, rdata;
  logic sel;
  logic [NR-1:0] wstrb;
  logic [31:0] model [NR];
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  comp_decoder i_comp_decoder (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .rd(rd), .wr(wr),
    .sel(sel), .rdata(rdata), .wstrb(wstrb)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic exp_sel(input logic [31:0] a);
    return (a[13:10] >= 4'd1) && (a[13:10] <= 4'd2);
  endfunction

  function automatic int exp_idx(input logic [31:0] a);
    return int'(a[13:2]) - 256;
  endfunction

  task automatic bus_read(input logic [31:0] a, output logic [31:0] d, output logic s);
    @(negedge clk); addr = a; rd = 1; wr = 0; #1; d = rdata; s = sel;
    @(negedge clk); rd = 0;
  endtask

  task automatic bus_write(input string req, input logic [31:0] a, input logic [31:0] d);
    logic [NR-1:0] es;
    int ix;
    es = '0;
    ix = exp_idx(a);
    if (exp_sel(a) && ix >= 0 && ix < NR) es[ix] = 1'b1;
    @(negedge clk); addr = a; wdata = d; wr = 1; rd = 0; #1;
    check(req, 32'(wstrb), 32'(es));
    @(negedge clk); wr = 0;
    if (es != '0) model[ix] = d;
  endtask

  task automatic read_all(input string req);
    logic [31:0] d; logic s;
    for (int i = 0; i < NR; i++) begin
      bus_read(32'h400 + 32'(i*4), d, s);
      check(req, d, model[i]);
    end
  endtask

  task automatic t_reset;
    for (int i = 0; i < NR; i++) model[i] = '0;
    read_all("R1");
  endtask

  task automatic t_select;
    logic [31:0] al [8] = '{32'h0, 32'h3FC, 32'h400, 32'h7FF, 32'h800, 32'hBFF, 32'hC00, 32'h1000};
    logic [31:0] d; logic s;
    foreach (al[i]) begin
      bus_read(al[i], d, s);
      check("R2 R4", 32'(s), 32'(exp_sel(al[i])));
    end
  endtask

  task automatic t_write_read;
    for (int i = 0; i < NR; i++) bus_write("R6", 32'h400 + 32'(i*4), 32'hA5000000 + 32'(i*17));
    read_all("R6");
  endtask

  task automatic t_top_bits;
    logic [31:0] d; logic s;
    bus_write("R3", 32'hFFFFC408, 32'hCAFE0002);
    bus_read(32'h408, d, s);
    check("R3", d, 32'hCAFE0002);
    bus_read(32'hABCDC404, d, s);
    check("R3", d, model[1]);
    check("R3", 32'(s), 32'd1);
  endtask

  task automatic t_byte_bits;
    logic [31:0] d; logic s;
    bus_write("R5", 32'h40F, 32'h12345678);
    bus_read(32'h40C, d, s);
    check("R5", d, 32'h12345678);
    bus_read(32'h411, d, s);
    check("R5", d, model[4]);
  endtask

  task automatic t_unselected_write;
    bus_write("R7", 32'h000, 32'hDEAD0000);
    bus_write("R7", 32'hC00, 32'hDEAD0001);
    bus_write("R7", 32'h1008, 32'hDEAD0002);
    read_all("R7");
  endtask

  task automatic t_quiet_read;
    logic [31:0] d; logic s;
    @(negedge clk); addr = 32'h404; rd = 0; wr = 0; #1;
    check("R8", rdata, 32'h0);
    bus_read(32'h004, d, s);
    check("R8", d, 32'h0);
  endtask

  task automatic t_unbacked;
    logic [31:0] d; logic s;
    bus_write("R9", 32'h420, 32'hBEEF0000);
    bus_write("R9", 32'hBFC, 32'hBEEF0001);
    bus_read(32'h420, d, s);
    check("R9", d, 32'h0);
    check("R9", 32'(s), 32'd1);
    read_all("R9");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_select();
    t_write_read();
    t_top_bits();
    t_byte_bits();
    t_unselected_write();
    t_quiet_read();
    t_unbacked();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule